// File: doc/BRIEF.md
# Dual-Function Interrupt Status Controller

This block gathers interrupt events for two independent controller functions, A and B, and reports them to a host through a small register bank and two active-low request lines. Each function has detailed status registers: two on the bus side and one on the DMA side. Each of these has its own enable register. A status bit latches on a one-cycle event pulse and clears when the host reads its register. The enabled bits are folded into two summary flags. These flags sit in a per-function top-level status word, together with an interrupt-on-the-fly flag and two mailbox bytes.

The host sees one 32-bit read/write port. Reads are combinational and take effect at the clock edge where the read strobe is high. While a function's sequencer is busy, only that function's top-level word can be reached. Function A always raises request line A. A configuration strap chooses whether function B raises line B or shares line A.

Top module: `dual_irq_status`

## Requirements
- R1: A synchronous active-high reset clears every status, enable and mailbox register of both functions, and drives `irq_a_n` and `irq_b_n` high.
- R2: A detailed status bit sets in the cycle after its event pulse. It clears at the clock edge where the host reads that register while the function is not busy. If an event for the same bit arrives in the read cycle, the bit stays set.
- R3: Top-word bit 1 is the bus summary. It is 1 when (bus status 0 AND bus enable 0) OR (bus status 1 AND bus enable 1) is nonzero. Disabled bits still latch and read back.
- R4: Top-word bit 0 is the DMA summary. It is 1 when (DMA status AND DMA enable) is nonzero.
- R5: Top-word bit 2 is the interrupt-on-the-fly flag. An event pulse sets it. Writing the top word with bit 2 = 1 clears it, and writing 0 there leaves it unchanged. A set pulse in the same cycle as a clear leaves it set.
- R6: Top-word bits 23:16 and 31:24 are two mailbox bytes. They are written and read by the host and have no effect on the summaries or the request lines. Top-word bits 15:3 read zero.
- R7: While `seq_busy[f]` is 1, function f's registers other than the top word read zero, ignore writes, and are not cleared by reads. Its status bits still latch events, and its top word stays fully accessible.
- R8: A request line goes low one cycle after any routed function has its fly flag, bus summary or DMA summary active. It returns high one cycle after all of them clear.
- R9: With `route_b_to_a` = 0, function B drives `irq_b_n`. With it at 1, function B drives `irq_a_n`, and `irq_b_n` stays high from the next cycle on.
- R10: Address bit 3 selects function A (0) or B (1). Bits 2:0 select the register: 0 top word, 1 bus status 0, 2 bus status 1, 3 DMA status, 4 bus enable 0, 5 bus enable 1, 6 DMA enable, 7 reads zero. Writes to status registers and to index 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Function select (bit 3) and register index (bits 2:0) |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data for the addressed register |
| seq_busy | input | 2 | Per-function sequencer busy |
| fly_evt | input | 2 | Per-function interrupt-on-the-fly pulse |
| bus0_evt | input | 2 x ST_W | Per-function bus status 0 event pulses |
| bus1_evt | input | 2 x ST_W | Per-function bus status 1 event pulses |
| dma_evt | input | 2 x ST_W | Per-function DMA status event pulses |
| route_b_to_a | input | 1 | Strap that moves function B onto line A |
| irq_a_n | output | 1 | Active-low request line A |
| irq_b_n | output | 1 | Active-low request line B |

## Verification
The bench builds the block with `ST_W` = 4. At that width every pairing of a 4-bit enable with a 4-bit event pattern (256 cases) can be swept for the DMA summary on function A and for bus status 0 on function B. Each case predicts the summary bit and the request line from the AND of the two values. Each case also confirms that the status bit latched regardless of its enable and cleared on read. Directed sequences cover the remaining corners:
- a set event landing on a clearing read;
- a fly-flag set racing a clear;
- busy blocking;
- strap routing;
- mailbox isolation.

// File: rtl/dis_pkg.sv
package dis_pkg;

    localparam int DATA_W    = 32;
    localparam int MBOX_W    = 8;
    localparam int REG_IDX_W = 3;

    localparam int DMA_SUM_BIT = 0;
    localparam int BUS_SUM_BIT = 1;
    localparam int FLY_BIT     = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_TOP  = 3'd0,
        REG_BUS0 = 3'd1,
        REG_BUS1 = 3'd2,
        REG_DMA  = 3'd3,
        REG_BEN0 = 3'd4,
        REG_BEN1 = 3'd5,
        REG_DEN  = 3'd6,
        REG_NONE = 3'd7
    } reg_sel_e;

    // Bit order matches the top-word layout: fly at 2, bus at 1, dma at 0.
    typedef struct packed {
        logic fly;
        logic bus_sum;
        logic dma_sum;
    } irq_flags_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    function automatic logic [DATA_W-1:0] pack_top(irq_flags_t f,
                                                   logic [MBOX_W-1:0] mb0,
                                                   logic [MBOX_W-1:0] mb1);
        return {mb1, mb0, 8'h00, 5'b00000, f};
    endfunction

    function automatic logic flags_active(irq_flags_t f);
        return f.fly | f.bus_sum | f.dma_sum;
    endfunction

endpackage

// File: rtl/dis_cor_reg.sv
module dis_cor_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    // A new event wins over the clearing read in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= (q_r & ~{W{rd_clr}}) | evt;
    end

    assign q = q_r;

    assert_evt_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/dis_func_regs.sv
module dis_func_regs
    import dis_pkg::*;
#(
    parameter int ST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req,
    input  logic              busy,
    input  logic              fly_evt,
    input  logic [ST_W-1:0]   bus0_evt,
    input  logic [ST_W-1:0]   bus1_evt,
    input  logic [ST_W-1:0]   dma_evt,
    output logic [DATA_W-1:0] rdata,
    output irq_flags_t        flags
);
    logic                 open_acc;
    logic [ST_W-1:0]      bus0_q, bus1_q, dma_q;
    logic [ST_W-1:0]      ben0_q, ben1_q, den_q;
    logic [MBOX_W-1:0]    mb0_q, mb1_q;
    logic                 fly_q;
    logic                 top_wr;
    logic                 fly_clr;
    logic                 unused_wdata;

    assign open_acc     = !busy;
    assign top_wr       = req.wr && (req.sel == REG_TOP);
    assign fly_clr      = top_wr && req.wdata[FLY_BIT];
    assign unused_wdata = ^req.wdata;

    dis_cor_reg #(.W(ST_W)) u_bus0 (
        .clk(clk), .rst(rst), .evt(bus0_evt),
        .rd_clr(req.rd && open_acc && (req.sel == REG_BUS0)), .q(bus0_q));
    dis_cor_reg #(.W(ST_W)) u_bus1 (
        .clk(clk), .rst(rst), .evt(bus1_evt),
        .rd_clr(req.rd && open_acc && (req.sel == REG_BUS1)), .q(bus1_q));
    dis_cor_reg #(.W(ST_W)) u_dma (
        .clk(clk), .rst(rst), .evt(dma_evt),
        .rd_clr(req.rd && open_acc && (req.sel == REG_DMA)), .q(dma_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            ben0_q <= '0;
            ben1_q <= '0;
            den_q  <= '0;
        end else if (req.wr && open_acc) begin
            case (req.sel)
                REG_BEN0: ben0_q <= req.wdata[ST_W-1:0];
                REG_BEN1: ben1_q <= req.wdata[ST_W-1:0];
                REG_DEN:  den_q  <= req.wdata[ST_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mb0_q <= '0;
            mb1_q <= '0;
            fly_q <= 1'b0;
        end else begin
            if (top_wr) begin
                mb0_q <= req.wdata[23:16];
                mb1_q <= req.wdata[31:24];
            end
            fly_q <= fly_evt | (fly_q & ~fly_clr);
        end
    end

    always_comb begin
        flags.fly     = fly_q;
        flags.bus_sum = |((bus0_q & ben0_q) | (bus1_q & ben1_q));
        flags.dma_sum = |(dma_q & den_q);
    end

    always_comb begin
        rdata = '0;
        if (req.sel == REG_TOP) begin
            rdata = pack_top(flags, mb0_q, mb1_q);
        end else if (open_acc) begin
            case (req.sel)
                REG_BUS0: rdata = DATA_W'(bus0_q);
                REG_BUS1: rdata = DATA_W'(bus1_q);
                REG_DMA:  rdata = DATA_W'(dma_q);
                REG_BEN0: rdata = DATA_W'(ben0_q);
                REG_BEN1: rdata = DATA_W'(ben1_q);
                REG_DEN:  rdata = DATA_W'(den_q);
                default:  rdata = '0;
            endcase
        end
    end

    assert_fly_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (flags.fly && !(req.wr && req.sel == REG_TOP && req.wdata[FLY_BIT]))
        |=> flags.fly);

    assert_fly_set_R5: assert property (@(posedge clk) disable iff (rst)
        fly_evt |=> flags.fly);

    assert_busy_en_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && req.wr) |=> ($stable(ben0_q) && $stable(ben1_q) && $stable(den_q)));

    assert_busy_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && req.rd) |=> ((dma_q & $past(dma_q)) == $past(dma_q)));

endmodule

// File: rtl/dis_irq_route.sv
module dis_irq_route
    import dis_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       route_b_to_a,
    input  irq_flags_t flags_a,
    input  irq_flags_t flags_b,
    output logic       irq_a_n,
    output logic       irq_b_n
);
    logic act_a, act_b, want_a, want_b;

    assign act_a  = flags_active(flags_a);
    assign act_b  = flags_active(flags_b);
    assign want_a = act_a | (route_b_to_a & act_b);
    assign want_b = ~route_b_to_a & act_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_a_n <= 1'b1;
            irq_b_n <= 1'b1;
        end else begin
            irq_a_n <= ~want_a;
            irq_b_n <= ~want_b;
        end
    end

    assert_irq_a_low_R8: assert property (@(posedge clk) disable iff (rst)
        (flags_a.fly || flags_a.bus_sum || flags_a.dma_sum) |=> !irq_a_n);

    assert_irq_a_high_R8: assert property (@(posedge clk) disable iff (rst)
        (!act_a && !(route_b_to_a && act_b)) |=> irq_a_n);

    assert_irq_b_idle_R9: assert property (@(posedge clk) disable iff (rst)
        route_b_to_a |=> irq_b_n);

    assert_irq_b_shared_R9: assert property (@(posedge clk) disable iff (rst)
        (route_b_to_a && act_b) |=> !irq_a_n);

endmodule

// File: rtl/dual_irq_status.sv
module dual_irq_status
    import dis_pkg::*;
#(
    parameter int ST_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [3:0]                addr,
    input  logic                      rd_en,
    input  logic                      wr_en,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    input  logic [1:0]                seq_busy,
    input  logic [1:0]                fly_evt,
    input  logic [1:0][ST_W-1:0]      bus0_evt,
    input  logic [1:0][ST_W-1:0]      bus1_evt,
    input  logic [1:0][ST_W-1:0]      dma_evt,
    input  logic                      route_b_to_a,
    output logic                      irq_a_n,
    output logic                      irq_b_n
);
    localparam int NFUNC = 2;

    logic [NFUNC-1:0][DATA_W-1:0] func_rdata;
    irq_flags_t [NFUNC-1:0]       func_flags;

    for (genvar f = 0; f < NFUNC; f++) begin : g_func
        host_req_t req_f;
        always_comb begin
            req_f.rd    = rd_en && (addr[3] == f[0]);
            req_f.wr    = wr_en && (addr[3] == f[0]);
            req_f.sel   = reg_sel_e'(addr[2:0]);
            req_f.wdata = wdata;
        end

        dis_func_regs #(.ST_W(ST_W)) u_regs (
            .clk      (clk),
            .rst      (rst),
            .req      (req_f),
            .busy     (seq_busy[f]),
            .fly_evt  (fly_evt[f]),
            .bus0_evt (bus0_evt[f]),
            .bus1_evt (bus1_evt[f]),
            .dma_evt  (dma_evt[f]),
            .rdata    (func_rdata[f]),
            .flags    (func_flags[f])
        );
    end

    assign rdata = func_rdata[addr[3]];

    dis_irq_route u_route (
        .clk          (clk),
        .rst          (rst),
        .route_b_to_a (route_b_to_a),
        .flags_a      (func_flags[0]),
        .flags_b      (func_flags[1]),
        .irq_a_n      (irq_a_n),
        .irq_b_n      (irq_b_n)
    );

endmodule

// File: tb/dual_irq_status_tb.sv
module dual_irq_status_tb;
    localparam int W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        addr = '0;
    logic              rd_en = 1'b0, wr_en = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [1:0]        seq_busy = '0;
    logic [1:0]        fly_evt = '0;
    logic [1:0][W-1:0] bus0_evt = '0, bus1_evt = '0, dma_evt = '0;
    logic              route_b_to_a = 1'b0;
    logic              irq_a_n, irq_b_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dual_irq_status #(.ST_W(W)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .seq_busy(seq_busy), .fly_evt(fly_evt),
        .bus0_evt(bus0_evt), .bus1_evt(bus1_evt), .dma_evt(dma_evt),
        .route_b_to_a(route_b_to_a), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n));

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        rd_en = 0; wr_en = 0; fly_evt = '0;
        bus0_evt = '0; bus1_evt = '0; dma_evt = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(); addr = a; wr_en = 1; wdata = d;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        cyc(); addr = a; rd_en = 1; #1 d = rdata;
    endtask

    task automatic idle();
        cyc();
    endtask

    task automatic peek();
        cyc(); #1;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state of every register and both lines
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], d);
            chk("R1 reg", d, 0);
        end
        chk("R1 irq_a_n", {31'b0, irq_a_n}, 1);
        chk("R1 irq_b_n", {31'b0, irq_b_n}, 1);

        // R4/R8/R2: exhaustive DMA enable x event sweep on function A
        for (int en = 0; en < 16; en++) begin
            for (int pat = 0; pat < 16; pat++) begin
                logic s;
                s = |(en[3:0] & pat[3:0]);
                wr(4'h6, en);
                cyc(); dma_evt[0] = pat[3:0];
                idle();
                rd(4'h0, d);
                chk("R4 dma summary", {31'b0, d[0]}, {31'b0, s});
                chk("R8 irq_a_n level", {31'b0, irq_a_n}, {31'b0, !s});
                rd(4'h3, d);
                chk("R2 dma latch", d, pat);
                idle();
                peek();
                chk("R8 irq_a_n release", {31'b0, irq_a_n}, 1);
            end
        end

        // R3/R9: exhaustive bus enable 0 x event sweep on function B (line B)
        for (int en = 0; en < 16; en++) begin
            for (int pat = 0; pat < 16; pat++) begin
                logic s;
                s = |(en[3:0] & pat[3:0]);
                wr(4'hC, en);
                cyc(); bus0_evt[1] = pat[3:0];
                idle();
                rd(4'h8, d);
                chk("R3 bus summary", {31'b0, d[1]}, {31'b0, s});
                chk("R9 irq_b_n level", {31'b0, irq_b_n}, {31'b0, !s});
                chk("R9 irq_a_n quiet", {31'b0, irq_a_n}, 1);
                rd(4'h9, d);
                chk("R3 disabled bits latch", d, pat);
                idle();
            end
        end

        // R3: bus status 1 with its own enable
        wr(4'hC, 0);
        wr(4'hD, 32'h4);
        cyc(); bus1_evt[1] = 4'b0011;
        idle(); rd(4'h8, d);
        chk("R3 bus1 masked", {31'b0, d[1]}, 0);
        cyc(); bus1_evt[1] = 4'b0100;
        idle(); rd(4'h8, d);
        chk("R3 bus1 enabled", {31'b0, d[1]}, 1);
        rd(4'hA, d);
        chk("R3 bus1 read", d, 32'h7);
        wr(4'hD, 0);

        // R2: event arriving on the clearing read keeps the bit
        cyc(); bus1_evt[0] = 4'b0001;
        cyc(); addr = 4'h2; rd_en = 1; bus1_evt[0] = 4'b0010; #1 d = rdata;
        chk("R2 pre-read", d, 32'h1);
        rd(4'h2, d);
        chk("R2 set wins over clear", d, 32'h2);
        rd(4'h2, d);
        chk("R2 cleared", d, 0);

        // R5: fly flag set / write-zero / race / write-one
        wr(4'h6, 0);
        cyc(); fly_evt[0] = 1;
        idle(); rd(4'h0, d);
        chk("R5 fly set", {31'b0, d[2]}, 1);
        chk("R5 irq from fly", {31'b0, irq_a_n}, 0);
        wr(4'h0, 32'h0000_0000);
        rd(4'h0, d);
        chk("R5 write zero keeps", {31'b0, d[2]}, 1);
        wr(4'h0, 32'h4); fly_evt[0] = 1;
        rd(4'h0, d);
        chk("R5 set beats clear", {31'b0, d[2]}, 1);
        wr(4'h0, 32'h4);
        rd(4'h0, d);
        chk("R5 write one clears", {31'b0, d[2]}, 0);
        idle(); peek();
        chk("R5 irq released", {31'b0, irq_a_n}, 1);

        // R6: mailboxes, isolation from interrupts and between functions
        wr(4'h0, 32'hA55A_FFF8);
        rd(4'h0, d);
        chk("R6 mailbox A", d, 32'hA55A_0000);
        rd(4'h8, d);
        chk("R6 mailbox B untouched", d, 0);
        idle(); peek();
        chk("R6 no irq", {30'b0, irq_a_n, irq_b_n}, 3);

        // R7: busy function A
        wr(4'h6, 32'hF);
        cyc(); dma_evt[0] = 4'b1001; seq_busy[0] = 1;
        wr(4'h6, 0);
        rd(4'h3, d);
        chk("R7 busy read zero", d, 0);
        rd(4'h6, d);
        chk("R7 busy enable read zero", d, 0);
        rd(4'h0, d);
        chk("R7 top readable", {31'b0, d[0]}, 1);
        wr(4'h0, 32'h1200_0000);
        rd(4'h0, d);
        chk("R7 top writable", d[31:24], 32'h12);
        cyc(); seq_busy[0] = 0;
        rd(4'h6, d);
        chk("R7 write ignored", d, 32'hF);
        rd(4'h3, d);
        chk("R7 read did not clear", d, 32'h9);
        wr(4'h6, 0);

        // R10: index 7 and status-register writes
        wr(4'h3, 32'hF);
        rd(4'h3, d);
        chk("R10 status write ignored", d, 0);
        wr(4'h7, 32'hF);
        rd(4'h7, d);
        chk("R10 index 7 zero", d, 0);

        // R9: strap moves B onto line A
        route_b_to_a = 1;
        cyc(); fly_evt[1] = 1;
        idle(); peek();
        chk("R9 routed to A", {30'b0, irq_a_n, irq_b_n}, 2'b01);
        route_b_to_a = 0;
        idle(); peek();
        chk("R9 back on B", {30'b0, irq_a_n, irq_b_n}, 2'b10);
        wr(4'h8, 32'h4);
        idle(); peek();
        chk("R9 cleared", {30'b0, irq_a_n, irq_b_n}, 2'b11);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule